// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Configuration-Start Instruction

This block is the serial test and programming port of a configuration memory device. A 16-state controller follows the test-mode select line on each rising test-clock edge and steers an 8-bit instruction register and a set of data registers between the serial data input and the serial data output. The block provides a one-bit bypass register, a 32-bit device identity word and a 32-bit user-defined word. For the boundary-scan register it supplies only the select and the capture, shift and update strobes, because the boundary cells sit outside the block.

When the instruction register is captured, it loads a fixed pattern that carries two live status flags: whether the device is in programming mode and whether read-out protection is set. Both flags come from outside the block. A device-specific instruction restarts configuration of the downstream logic. It does this by pulling an active-low start line for one test-clock period each time the controller enters Run-Test/Idle. Further decoded outputs tell the pad ring to float every output, or to drive the pins from the boundary cells.

Top module: `jtag_isp_tap`

## Requirements
- R1: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. Test-Logic-Reset, and `rst` high at a rising edge, make the identity instruction (0xFE) current, or bypass (0xFF) when `HAS_IDCODE` is 0.
- R2: The instruction register is 8 bits wide and shifts towards `tdo` with bit 0 leaving first. In Capture-IR it loads bit7..bit0 = 0,0,0,`isp_mode_i`,`secure_i`,0,0,1.
- R3: Opcode decode selects the data register. 0xFE selects the identity word and 0xFD selects the user word. 0x00 (external test) and 0x01 (sample/preload) select the boundary register. Every other value selects bypass, including 0xFF, 0xFA (clamp), 0xFC (float), 0xEE (config start) and any unlisted code.
- R4: The identity word is `ID_VERSION` in bits 31:28, 0x50 in bits 27:20, `ID_PRODUCT` in bits 19:12 and 0x49 in bits 11:1, with bit 0 at 1.
- R5: With the user instruction current, Capture-DR loads `user_code_i` into the 32-bit shifter, and Shift-DR sends it out bit 0 first.
- R6: The bypass register is a single stage that captures 0. While shifting, `tdo` repeats `tdi` one shift later.
- R7: While opcode 0xFC is current, `pins_hiz_o` is 1; it is 0 under any other instruction.
- R8: `pins_bsr_o` is 1 only for opcodes 0x00 and 0xFA. `bsr_sel_o` is 1 only for 0x00 and 0x01. With the boundary register selected, the serial output follows `bsr_so_i`, and `dr_capture_o`, `dr_shift_o` and `dr_update_o` mark the Capture-DR, Shift-DR and Update-DR states.
- R9: With opcode 0xEE current, `cfg_start_n_o` goes low for exactly one `tck` period, starting at the edge that enters Run-Test/Idle. Staying in Run-Test/Idle produces no further pulse.
- R10: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 only during Shift-IR and Shift-DR; a 0 means the pin floats.
- R11: `rst` is synchronous and active high. After it, `tdo_oe` is 0, `cfg_start_n_o` is 1 and `pins_hiz_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| isp_mode_i | input | 1 | Device is in programming mode |
| secure_i | input | 1 | Read-out protection is set |
| user_code_i | input | 32 | User-defined word |
| bsr_so_i | input | 1 | Serial output of the external boundary cells |
| bsr_sel_o | output | 1 | Boundary register selected |
| dr_capture_o | output | 1 | Capture-DR state |
| dr_shift_o | output | 1 | Shift-DR state |
| dr_update_o | output | 1 | Update-DR state |
| pins_hiz_o | output | 1 | Float all device outputs |
| pins_bsr_o | output | 1 | Drive device pins from boundary cells |
| cfg_start_n_o | output | 1 | Active-low configuration restart pulse |

## Verification
The bench builds the block with `ID_VERSION` = 4'h5, `ID_PRODUCT` = 8'h26 and `HAS_IDCODE` = 1. Because the version field is nonzero, a misplaced or truncated version field shows up in the identity read-out, and the identity instruction becomes the reset default that the random state walks must return to. Random status flags, user words, bypass streams and unlisted opcodes are mixed with directed scans of every listed opcode and with a repeated Run-Test/Idle stay after the config-start instruction.

// File: rtl/jtag_isp_pkg.sv
package jtag_isp_pkg;

    localparam int IR_W = 8;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
    localparam logic [IR_W-1:0] OP_CLAMP  = 8'hFA;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 8'hFC;
    localparam logic [IR_W-1:0] OP_USER   = 8'hFD;
    localparam logic [IR_W-1:0] OP_IDENT  = 8'hFE;
    localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;
    localparam logic [IR_W-1:0] OP_CFGGO  = 8'hEE;

    localparam logic [7:0]  FAMILY_CODE = 8'h50;
    localparam logic [10:0] MAKER_CODE  = 11'h049;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_st_e;

    typedef enum logic [1:0] {DR_BYP, DR_IDENT, DR_USER, DR_BSR} dr_sel_e;

    function automatic tap_st_e tap_next(input tap_st_e st, input logic tms);
        case (st)
            ST_RESET:  return tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            default:   return tms ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] op, input logic has_id);
        case (op)
            OP_IDENT:             return has_id ? DR_IDENT : DR_BYP;
            OP_USER:              return DR_USER;
            OP_EXTEST, OP_SAMPLE: return DR_BSR;
            default:              return DR_BYP;
        endcase
    endfunction

    function automatic logic [IR_W-1:0] ir_capture(input logic isp, input logic sec);
        return {3'b000, isp, sec, 3'b001};
    endfunction

    function automatic logic [ID_W-1:0] ident_word(input logic [3:0] ver, input logic [7:0] prod);
        return {ver, FAMILY_CODE, prod, MAKER_CODE, 1'b1};
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_isp_pkg::*;
(
    input  logic    tck,
    input  logic    rst,
    input  logic    tms,
    output tap_st_e st_o
);
    tap_st_e st_q;
    logic [2:0] hi_cnt;

    always_ff @(posedge tck) begin
        if (rst) st_q <= ST_RESET;
        else     st_q <= tap_next(st_q, tms);
    end

    // count of consecutive high tms edges, saturating at five
    always_ff @(posedge tck) begin
        if (rst)              hi_cnt <= 3'd0;
        else if (!tms)        hi_cnt <= 3'd0;
        else if (hi_cnt != 5) hi_cnt <= hi_cnt + 3'd1;
    end

    assign st_o = st_q;

    // R1
    five_high_reset_chk: assert property (@(posedge tck) disable iff (rst)
        (hi_cnt == 3'd5) |-> (st_q == ST_RESET));
endmodule

// File: rtl/ir_unit.sv
module ir_unit
    import jtag_isp_pkg::*;
#(
    parameter bit HAS_IDCODE = 1'b1
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_st_e         st,
    input  logic            tdi,
    input  logic            isp_mode,
    input  logic            secure,
    output logic [IR_W-1:0] ir_cur_o,
    output logic            so_o
);
    localparam logic [IR_W-1:0] RESET_OP = HAS_IDCODE ? OP_IDENT : OP_BYPASS;

    logic [IR_W-1:0] sh_q;
    logic [IR_W-1:0] cur_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            sh_q  <= '0;
            cur_q <= RESET_OP;
        end else begin
            case (st)
                ST_RESET:  cur_q <= RESET_OP;
                ST_CAP_IR: sh_q  <= ir_capture(isp_mode, secure);
                ST_SH_IR:  sh_q  <= {tdi, sh_q[IR_W-1:1]};
                ST_UPD_IR: cur_q <= sh_q;
                default: ;
            endcase
        end
    end

    assign ir_cur_o = cur_q;
    assign so_o     = sh_q[0];

    // R2
    ir_capture_chk: assert property (@(posedge tck) disable iff (rst)
        (st == ST_CAP_IR) |=> (sh_q == {3'b000, $past(isp_mode), $past(secure), 3'b001}));

    // R1
    reset_op_chk: assert property (@(posedge tck) disable iff (rst)
        (st == ST_RESET) |=> (cur_q == RESET_OP));
endmodule

// File: rtl/dr_unit.sv
module dr_unit
    import jtag_isp_pkg::*;
#(
    parameter logic [3:0] ID_VERSION = 4'h0,
    parameter logic [7:0] ID_PRODUCT = 8'h23
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_st_e         st,
    input  dr_sel_e         sel,
    input  logic            tdi,
    input  logic [ID_W-1:0] user_code,
    input  logic            bsr_so,
    output logic            so_o
);
    localparam logic [ID_W-1:0] IDENT = ident_word(ID_VERSION, ID_PRODUCT);

    logic            byp_q;
    logic [ID_W-1:0] word_q;
    logic            word_sel;

    assign word_sel = (sel == DR_IDENT) || (sel == DR_USER);

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q  <= 1'b0;
            word_q <= '0;
        end else if (st == ST_CAP_DR) begin
            byp_q <= 1'b0;
            if (sel == DR_IDENT)     word_q <= IDENT;
            else if (sel == DR_USER) word_q <= user_code;
        end else if (st == ST_SH_DR) begin
            if (sel == DR_BYP) byp_q  <= tdi;
            if (word_sel)      word_q <= {tdi, word_q[ID_W-1:1]};
        end
    end

    always_comb begin
        case (sel)
            DR_IDENT, DR_USER: so_o = word_q[0];
            DR_BSR:            so_o = bsr_so;
            default:           so_o = byp_q;
        endcase
    end

    // R6
    bypass_zero_chk: assert property (@(posedge tck) disable iff (rst)
        (st == ST_CAP_DR && sel == DR_BYP) |=> (byp_q == 1'b0));

    // R5
    user_capture_chk: assert property (@(posedge tck) disable iff (rst)
        (st == ST_CAP_DR && sel == DR_USER) |=> (word_q == $past(user_code)));
endmodule

// File: rtl/jtag_isp_tap.sv
module jtag_isp_tap
    import jtag_isp_pkg::*;
#(
    parameter logic [3:0] ID_VERSION = 4'h0,
    parameter logic [7:0] ID_PRODUCT = 8'h23,
    parameter bit         HAS_IDCODE = 1'b1
) (
    input  logic        tck,
    input  logic        rst,
    input  logic        tms,
    input  logic        tdi,
    output logic        tdo,
    output logic        tdo_oe,
    input  logic        isp_mode_i,
    input  logic        secure_i,
    input  logic [31:0] user_code_i,
    input  logic        bsr_so_i,
    output logic        bsr_sel_o,
    output logic        dr_capture_o,
    output logic        dr_shift_o,
    output logic        dr_update_o,
    output logic        pins_hiz_o,
    output logic        pins_bsr_o,
    output logic        cfg_start_n_o
);
    tap_st_e         st;
    logic [IR_W-1:0] ir_cur;
    logic            ir_so;
    logic            dr_so;
    dr_sel_e         sel;
    logic            was_idle_q;
    logic            tdo_q;
    logic            oe_q;

    tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .st_o(st));

    ir_unit #(.HAS_IDCODE(HAS_IDCODE)) u_ir (
        .tck(tck), .rst(rst), .st(st), .tdi(tdi),
        .isp_mode(isp_mode_i), .secure(secure_i),
        .ir_cur_o(ir_cur), .so_o(ir_so)
    );

    assign sel = dr_decode(ir_cur, HAS_IDCODE);

    dr_unit #(.ID_VERSION(ID_VERSION), .ID_PRODUCT(ID_PRODUCT)) u_dr (
        .tck(tck), .rst(rst), .st(st), .sel(sel), .tdi(tdi),
        .user_code(user_code_i), .bsr_so(bsr_so_i), .so_o(dr_so)
    );

    // serial output retimed to the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= (st == ST_SH_IR) || (st == ST_SH_DR);
            if (st == ST_SH_IR)      tdo_q <= ir_so;
            else if (st == ST_SH_DR) tdo_q <= dr_so;
        end
    end

    always_ff @(posedge tck) begin
        if (rst) was_idle_q <= 1'b0;
        else     was_idle_q <= (st == ST_IDLE);
    end

    assign tdo           = tdo_q;
    assign tdo_oe        = oe_q;
    assign cfg_start_n_o = !((st == ST_IDLE) && !was_idle_q && (ir_cur == OP_CFGGO));
    assign pins_hiz_o    = (ir_cur == OP_HIGHZ);
    assign pins_bsr_o    = (ir_cur == OP_EXTEST) || (ir_cur == OP_CLAMP);
    assign bsr_sel_o     = (sel == DR_BSR);
    assign dr_capture_o  = bsr_sel_o && (st == ST_CAP_DR);
    assign dr_shift_o    = bsr_sel_o && (st == ST_SH_DR);
    assign dr_update_o   = bsr_sel_o && (st == ST_UPD_DR);

    // R9
    cfg_single_chk: assert property (@(posedge tck) disable iff (rst)
        !cfg_start_n_o |=> cfg_start_n_o);

    // R9
    cfg_context_chk: assert property (@(posedge tck) disable iff (rst)
        !cfg_start_n_o |-> (st == ST_IDLE && ir_cur == OP_CFGGO));

    // R10
    tdo_drive_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (st == ST_SH_IR || st == ST_SH_DR));

    // R7
    hiz_bypass_chk: assert property (@(posedge tck) disable iff (rst)
        pins_hiz_o |-> (sel == DR_BYP));
endmodule

// File: tb/test_jtag_isp_tap.sv
module test_jtag_isp_tap;
    logic        tck = 1'b0;
    logic        rst = 1'b1;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        isp = 1'b0;
    logic        sec = 1'b0;
    logic [31:0] ucode = 32'h0;
    logic        bsr_so = 1'b0;
    logic        tdo, tdo_oe, bsr_sel, dcap, dsh, dupd, hiz, pbsr, cfg_n;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit oe_seen_low;

    localparam logic [3:0] VER  = 4'h5;
    localparam logic [7:0] PROD = 8'h26;

    jtag_isp_tap #(.ID_VERSION(VER), .ID_PRODUCT(PROD), .HAS_IDCODE(1'b1)) i_jtag_isp_tap (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .isp_mode_i(isp), .secure_i(sec), .user_code_i(ucode), .bsr_so_i(bsr_so),
        .bsr_sel_o(bsr_sel), .dr_capture_o(dcap), .dr_shift_o(dsh), .dr_update_o(dupd),
        .pins_hiz_o(hiz), .pins_bsr_o(pbsr), .cfg_start_n_o(cfg_n)
    );

    always #5 tck = ~tck;

    function automatic logic [31:0] exp_ident();
        return {VER, 8'h50, PROD, 11'h049, 1'b1};
    endfunction

    function automatic logic [7:0] exp_ircap(input logic i, input logic s);
        return {3'b000, i, s, 3'b001};
    endfunction

    function automatic logic [63:0] exp_bypass(input logic [63:0] din);
        return {din[62:0], 1'b0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m);
        @(negedge tck); #1;
        tms = m;
        @(posedge tck); #1;
    endtask

    task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge tck); #1;
            dout[i] = tdo;
            if (!tdo_oe) oe_seen_low = 1;
            tdi = din[i];
            tms = (i == n - 1);
            @(posedge tck); #1;
        end
    endtask

    // from Run-Test/Idle, ends at the edge that re-enters Run-Test/Idle
    task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
        logic [63:0] o;
        tick(1); tick(1); tick(0); tick(0);
        shift_bits(8, {56'h0, op}, o);
        tick(1); tick(0);
        cap = o[7:0];
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        tick(1); tick(0); tick(0);
        shift_bits(n, din, dout);
        tick(1); tick(0);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] o, d;
        logic [7:0]  c, op;
        logic        ok;
        void'($urandom(32'd1343));
        repeat (3) @(posedge tck);
        #1;
        // R11 reset state
        check("R11 tdo_oe", tdo_oe, 0);
        check("R11 cfg_start_n", cfg_n, 1);
        check("R11 pins_hiz", hiz, 0);
        @(negedge tck); rst = 0;
        tick(0);
        check("R10 tdo_oe idle", tdo_oe, 0);
        // R1 R4: identity word selected after reset
        scan_dr(32, 64'h0, o);
        check("R1 R4 ident after reset", o[31:0], exp_ident());
        check("R11 cfg no pulse on reset-op idle", cfg_n, 1);

        // R2 capture pattern under random status flags
        for (int k = 0; k < 4; k++) begin
            isp = $urandom; sec = $urandom;
            oe_seen_low = 0;
            scan_ir(8'hFF, c);
            check("R2 ir capture", c, exp_ircap(isp, sec));
            check("R10 tdo_oe in shift", oe_seen_low, 0);
        end

        // R6 bypass random streams
        for (int k = 0; k < 3; k++) begin
            d = {$urandom, $urandom};
            scan_dr(24, d, o);
            check("R6 bypass delay", o[23:0], exp_bypass(d) & 64'hFFFFFF);
        end

        // R5 user word
        scan_ir(8'hFD, c);
        for (int k = 0; k < 3; k++) begin
            ucode = $urandom;
            scan_dr(32, 64'h0, o);
            check("R5 user word", o[31:0], ucode);
        end
        check("R8 no bsr select for user", bsr_sel, 0);

        // R4 identity via explicit opcode
        scan_ir(8'hFE, c);
        scan_dr(32, 64'h0, o);
        check("R4 ident explicit", o[31:0], exp_ident());

        // R3 unlisted opcodes select bypass
        for (int k = 0; k < 4; k++) begin
            do op = $urandom; while (op inside {8'h00, 8'h01, 8'hFA, 8'hFC, 8'hFD, 8'hFE, 8'hEE});
            scan_ir(op, c);
            d = {32'h0, $urandom};
            scan_dr(16, d, o);
            check("R3 unlisted opcode bypass", o[15:0], exp_bypass(d) & 64'hFFFF);
            check("R7 no float for unlisted", hiz, 0);
        end

        // R7 float instruction
        scan_ir(8'hFC, c);
        check("R7 pins_hiz", hiz, 1);
        check("R8 pins_bsr under float", pbsr, 0);
        scan_dr(8, 64'hA5, o);
        check("R3 R7 float uses bypass", o[7:0], 8'h4A);

        // R8 sample/preload
        scan_ir(8'h01, c);
        check("R7 float cleared", hiz, 0);
        check("R8 bsr_sel sample", bsr_sel, 1);
        check("R8 pins_bsr sample", pbsr, 0);
        bsr_so = 1;
        tick(1); tick(0);
        check("R8 dr_capture", dcap, 1);
        tick(0);
        check("R8 dr_shift", dsh, 1);
        shift_bits(8, 64'h0, o);
        check("R8 bsr serial", o[7:0], 8'hFF);
        tick(1);
        check("R8 dr_update", dupd, 1);
        tick(0);
        bsr_so = 0;

        // R8 external test and clamp
        scan_ir(8'h00, c);
        check("R8 pins_bsr extest", pbsr, 1);
        check("R8 bsr_sel extest", bsr_sel, 1);
        scan_ir(8'hFA, c);
        check("R8 pins_bsr clamp", pbsr, 1);
        check("R8 bsr_sel clamp", bsr_sel, 0);
        scan_dr(8, 64'h3C, o);
        check("R3 clamp bypass", o[7:0], 8'h78);

        // R9 config-start pulse
        scan_ir(8'hEE, c);
        check("R9 pulse on idle entry", cfg_n, 0);
        tick(0);
        check("R9 pulse one period", cfg_n, 1);
        ok = 1;
        for (int k = 0; k < 6; k++) begin
            tick(0);
            if (!cfg_n) ok = 0;
        end
        check("R9 no repeat in idle", ok, 1);

        // R1 random walks then five high tms
        for (int k = 0; k < 3; k++) begin
            scan_ir(8'hFD, c);
            for (int j = 0; j < 20; j++) tick($urandom);
            for (int j = 0; j < 5; j++) tick(1);
            check("R10 tdo_oe after reset walk", tdo_oe, 0);
            tick(0);
            ucode = 32'h0;
            scan_dr(32, 64'h0, o);
            check("R1 reset walk ident", o[31:0], exp_ident());
        end

        // R11 synchronous reset from the user instruction
        scan_ir(8'hFD, c);
        @(negedge tck); rst = 1;
        @(posedge tck); #1;
        @(negedge tck); rst = 0; tms = 0;
        @(posedge tck); #1;
        scan_dr(32, 64'h0, o);
        check("R11 R1 ident after rst", o[31:0], exp_ident());

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule